// File: doc/BRIEF.md
# Variable Memory Range Register Codec

This block keeps a shadow copy of the register pair that describes one variable memory range: a base register holding the page-aligned start address and an 8-bit memory type, and a mask register holding the page-aligned address mask and a valid bit. It converts a software-style request of page base, page count and type into that pair. A request with a page count of zero turns the range off instead. On request it also turns the stored pair back into page base, page count and type.

Its third function supports restoring a saved configuration. A desired pair is compared against the stored pair over the bits that carry meaning. The reserved field in each register and the bits above the implemented physical address width are ignored. Only a register that differs in a significant bit is replaced, and the block reports which register, if any, was replaced. Addresses are in 4 KiB pages, and the physical address width is a parameter.

Top module: `vrr_codec`

## Requirements
- R1: After reset, both stored registers, the read outputs and all change flags are zero.
- R2: A write with a non-zero page count stores a base register whose bits [PHYS_W-1:12] hold the page base and bits [7:0] hold the type, with every other bit zero. The new value is visible from the cycle after the request.
- R3: Such a write stores a mask register whose bits [PHYS_W-1:12] hold the two's complement of the page count, taken modulo 2^(PHYS_W-12). Bit 11, the valid bit, is set and every other bit is zero.
- R4: A write with a page count of zero clears both stored registers to zero.
- R5: A read request makes rd_valid_o high for exactly the next cycle. In that cycle rd_base_o equals stored base bits [PHYS_W-1:12] and rd_type_o equals stored base bits [7:0].
- R6: When bit 11 of the stored mask is clear, a read reports base, page count and type all as zero, whatever the other mask bits hold.
- R7: When the range is valid, the page count read back is the two's complement, in PHYS_W-11 bits, of the stored mask bits [PHYS_W-1:12] with a 1 placed above them. An all-zero valid mask therefore reads as 2^(PHYS_W-12) pages.
- R8: The comparison looks only at base bits [PHYS_W-1:12] and [7:0], and at mask bits [PHYS_W-1:11]. Differences in base bits [11:8], mask bits [10:0] or any bit at or above PHYS_W are ignored.
- R9: One cycle after a compare request, chg_base_o and chg_mask_o show which registers differed, and chg_o is their OR. Only a register that differed is replaced, by the desired value exactly as given. The flags are zero in cycles that do not follow a compare.
- R10: A write and a compare in the same cycle carry out the write only. All change flags are zero in the following cycle.
- R11: A read in the same cycle as a write or a compare decodes the pair as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Encode request |
| wr_base_i | input | PHYS_W-12 | Page base of the range |
| wr_size_i | input | PHYS_W-12 | Page count; zero disables |
| wr_type_i | input | 8 | Memory type code |
| rd_req_i | input | 1 | Decode request |
| rd_valid_o | output | 1 | Decode result valid |
| rd_base_o | output | PHYS_W-12 | Decoded page base |
| rd_size_o | output | PHYS_W-11 | Decoded page count |
| rd_type_o | output | 8 | Decoded type |
| cmp_req_i | input | 1 | Compare-and-update request |
| cmp_base_i | input | REG_W | Desired base register |
| cmp_mask_i | input | REG_W | Desired mask register |
| chg_o | output | 1 | Some register was replaced |
| chg_base_o | output | 1 | Base register was replaced |
| chg_mask_o | output | 1 | Mask register was replaced |
| reg_base_o | output | REG_W | Stored base register |
| reg_mask_o | output | REG_W | Stored mask register |

## Verification
A write can never produce a mask that is non-zero but has its valid bit clear. The same holds for a valid mask whose page bits are all zero. Yet both cases need a check: the first for the read zeroing, the second for the full-space page count. The bench reaches them through the compare path, which copies the desired pair in unchanged when it differs in significant bits. A read then decodes these states. Reserved bits and bits above the physical width come in the same way, with the significant bits kept equal, to show that no rewrite happens.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned TYPE_W     = 8;
  localparam int unsigned VALID_BIT  = 11;

  typedef logic [TYPE_W-1:0] mem_type_t;
  localparam mem_type_t MT_UC = 8'd0;
  localparam mem_type_t MT_WC = 8'd1;
  localparam mem_type_t MT_WT = 8'd4;
  localparam mem_type_t MT_WP = 8'd5;
  localparam mem_type_t MT_WB = 8'd6;
endpackage

// File: rtl/vrr_encode.sv
module vrr_encode
  import vrr_pkg::*;
#(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned PHYS_W = 36,
  localparam int unsigned PFN_W = PHYS_W - PAGE_SHIFT
) (
  input  logic [PFN_W-1:0] base_i,
  input  logic [PFN_W-1:0] size_i,
  input  mem_type_t        type_i,
  output logic [REG_W-1:0] base_reg_o,
  output logic [REG_W-1:0] mask_reg_o
);
  logic [PFN_W-1:0] neg_size;
  logic             off;

  assign off      = (size_i == '0);
  assign neg_size = PFN_W'(~size_i + 1'b1);

  always_comb begin
    if (off) begin
      base_reg_o = '0;
      mask_reg_o = '0;
    end else begin
      base_reg_o = REG_W'({base_i, {(PAGE_SHIFT-TYPE_W){1'b0}}, type_i});
      mask_reg_o = REG_W'({neg_size, 1'b1, {VALID_BIT{1'b0}}});
    end
  end
endmodule

// File: rtl/vrr_decode.sv
module vrr_decode
  import vrr_pkg::*;
#(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned PHYS_W = 36,
  localparam int unsigned PFN_W = PHYS_W - PAGE_SHIFT
) (
  input  logic [REG_W-1:0] base_reg_i,
  input  logic [REG_W-1:0] mask_reg_i,
  output logic [PFN_W-1:0] base_o,
  output logic [PFN_W:0]   size_o,
  output mem_type_t        type_o
);
  logic         vld;
  logic [PFN_W:0] filled;

  assign vld    = mask_reg_i[VALID_BIT];
  // fill above the implemented width so the negation yields the span
  assign filled = {1'b1, mask_reg_i[PHYS_W-1:PAGE_SHIFT]};

  always_comb begin
    if (vld) begin
      base_o = base_reg_i[PHYS_W-1:PAGE_SHIFT];
      size_o = (PFN_W+1)'(~filled + 1'b1);
      type_o = base_reg_i[TYPE_W-1:0];
    end else begin
      base_o = '0;
      size_o = '0;
      type_o = '0;
    end
  end
endmodule

// File: rtl/vrr_diff.sv
module vrr_diff
  import vrr_pkg::*;
#(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned PHYS_W = 36
) (
  input  logic [REG_W-1:0] cur_base_i,
  input  logic [REG_W-1:0] cur_mask_i,
  input  logic [REG_W-1:0] want_base_i,
  input  logic [REG_W-1:0] want_mask_i,
  output logic [1:0]       diff_o
);
  localparam logic [REG_W-1:0] PHYS_ONES = REG_W'({PHYS_W{1'b1}});
  localparam logic [REG_W-1:0] BASE_SIG  = PHYS_ONES & ~REG_W'(12'hF00);
  localparam logic [REG_W-1:0] MASK_SIG  = PHYS_ONES & ~REG_W'(12'h7FF);

  logic [1:0][REG_W-1:0] cur, want, sig;
  assign cur  = {cur_mask_i, cur_base_i};
  assign want = {want_mask_i, want_base_i};
  assign sig  = {MASK_SIG, BASE_SIG};

  for (genvar g = 0; g < 2; g++) begin : g_reg
    assign diff_o[g] = |((cur[g] ^ want[g]) & sig[g]);
  end
endmodule

// File: rtl/vrr_codec.sv
module vrr_codec
  import vrr_pkg::*;
#(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned PHYS_W = 36,
  localparam int unsigned PFN_W = PHYS_W - PAGE_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [PFN_W-1:0] wr_base_i,
  input  logic [PFN_W-1:0] wr_size_i,
  input  logic [7:0]       wr_type_i,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [PFN_W-1:0] rd_base_o,
  output logic [PFN_W:0]   rd_size_o,
  output logic [7:0]       rd_type_o,
  input  logic             cmp_req_i,
  input  logic [REG_W-1:0] cmp_base_i,
  input  logic [REG_W-1:0] cmp_mask_i,
  output logic             chg_o,
  output logic             chg_base_o,
  output logic             chg_mask_o,
  output logic [REG_W-1:0] reg_base_o,
  output logic [REG_W-1:0] reg_mask_o
);
  logic [REG_W-1:0] base_q, mask_q, enc_base, enc_mask;
  logic [PFN_W-1:0] dec_base;
  logic [PFN_W:0]   dec_size;
  mem_type_t        dec_type;
  logic [1:0]       diff;
  logic             cmp_go;

  vrr_encode #(.REG_W(REG_W), .PHYS_W(PHYS_W)) enc_i (
    .base_i(wr_base_i), .size_i(wr_size_i), .type_i(wr_type_i),
    .base_reg_o(enc_base), .mask_reg_o(enc_mask)
  );

  vrr_decode #(.REG_W(REG_W), .PHYS_W(PHYS_W)) dec_i (
    .base_reg_i(base_q), .mask_reg_i(mask_q),
    .base_o(dec_base), .size_o(dec_size), .type_o(dec_type)
  );

  vrr_diff #(.REG_W(REG_W), .PHYS_W(PHYS_W)) diff_i (
    .cur_base_i(base_q), .cur_mask_i(mask_q),
    .want_base_i(cmp_base_i), .want_mask_i(cmp_mask_i),
    .diff_o(diff)
  );

  // write has priority over compare
  assign cmp_go = cmp_req_i && !wr_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (wr_req_i) begin
      base_q <= enc_base;
      mask_q <= enc_mask;
    end else if (cmp_go) begin
      if (diff[0]) base_q <= cmp_base_i;
      if (diff[1]) mask_q <= cmp_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_base_o <= 1'b0;
      chg_mask_o <= 1'b0;
    end else begin
      chg_base_o <= cmp_go && diff[0];
      chg_mask_o <= cmp_go && diff[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_base_o  <= '0;
      rd_size_o  <= '0;
      rd_type_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) begin
        rd_base_o <= dec_base;
        rd_size_o <= dec_size;
        rd_type_o <= dec_type;
      end
    end
  end

  assign chg_o      = chg_base_o | chg_mask_o;
  assign reg_base_o = base_q;
  assign reg_mask_o = mask_q;
endmodule

// File: rtl/vrr_codec_chk.sv
module vrr_codec_chk #(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned PHYS_W = 36,
  localparam int unsigned PFN_W = PHYS_W - 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_req_i,
  input logic [PFN_W-1:0] wr_size_i,
  input logic             rd_req_i,
  input logic             rd_valid_o,
  input logic [PFN_W-1:0] rd_base_o,
  input logic [PFN_W:0]   rd_size_o,
  input logic [7:0]       rd_type_o,
  input logic             cmp_req_i,
  input logic             chg_o,
  input logic             chg_base_o,
  input logic [REG_W-1:0] reg_base_o,
  input logic [REG_W-1:0] reg_mask_o
);
  // R4
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && (wr_size_i == '0) |=> (reg_base_o == '0) && (reg_mask_o == '0));

  // R2
  write_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && (wr_size_i != '0) |=> reg_mask_o[11] && (reg_base_o[11:8] == 4'h0));

  // R5
  read_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);

  // R5
  read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);

  // R6
  read_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && !reg_mask_o[11] |=> (rd_base_o == '0) && (rd_size_o == '0) && (rd_type_o == '0));

  // R10
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> !chg_o);

  // R9
  base_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_i && !wr_req_i |=> chg_base_o || $stable(reg_base_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i && !cmp_req_i |=> $stable(reg_base_o) && $stable(reg_mask_o) && !chg_o);
endmodule

bind vrr_codec vrr_codec_chk #(.REG_W(REG_W), .PHYS_W(PHYS_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_req_i(wr_req_i), .wr_size_i(wr_size_i),
  .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .rd_base_o(rd_base_o),
  .rd_size_o(rd_size_o), .rd_type_o(rd_type_o), .cmp_req_i(cmp_req_i),
  .chg_o(chg_o), .chg_base_o(chg_base_o),
  .reg_base_o(reg_base_o), .reg_mask_o(reg_mask_o)
);

// File: tb/vrr_codec_tb_top.sv
module vrr_codec_tb_top;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned PHYS_W = 36;
  localparam int unsigned PFN_W  = PHYS_W - 12;
  localparam int unsigned NVEC   = 5;

  localparam logic [PFN_W-1:0] V_BASE [NVEC] = '{24'h000100, 24'h0C0000, 24'hFFF000, 24'h000000, 24'h800000};
  localparam logic [PFN_W-1:0] V_SIZE [NVEC] = '{24'h000100, 24'h040000, 24'h001000, 24'h000001, 24'h800000};
  localparam logic [7:0]       V_TYPE [NVEC] = '{8'd6, 8'd0, 8'd1, 8'd4, 8'd5};
  localparam logic [63:0]      V_EBASE[NVEC] = '{64'h0_0010_0006, 64'h0_C000_0000, 64'h0_000F_FF00_0001,
                                                  64'h0_0000_0004, 64'h8_0000_0005};
  localparam logic [63:0]      V_EMASK[NVEC] = '{64'hF_FFF0_0800, 64'hF_C000_0800, 64'hF_FF00_0800,
                                                  64'hF_FFFF_F800, 64'h8_0000_0800};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, cmp_req = 1'b0;
  logic [PFN_W-1:0] wr_base = '0, wr_size = '0;
  logic [7:0] wr_type = '0;
  logic [REG_W-1:0] cmp_base = '0, cmp_mask = '0;
  logic rd_valid, chg, chg_base, chg_mask;
  logic [PFN_W-1:0] rd_base;
  logic [PFN_W:0] rd_size;
  logic [7:0] rd_type;
  logic [REG_W-1:0] reg_base, reg_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vrr_codec #(.REG_W(REG_W), .PHYS_W(PHYS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_req_i(wr_req), .wr_base_i(wr_base), .wr_size_i(wr_size), .wr_type_i(wr_type),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_base_o(rd_base),
    .rd_size_o(rd_size), .rd_type_o(rd_type),
    .cmp_req_i(cmp_req), .cmp_base_i(cmp_base), .cmp_mask_i(cmp_mask),
    .chg_o(chg), .chg_base_o(chg_base), .chg_mask_o(chg_mask),
    .reg_base_o(reg_base), .reg_mask_o(reg_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [PFN_W-1:0] b, input logic [PFN_W-1:0] s, input logic [7:0] t);
    @(negedge clk);
    wr_req = 1'b1; wr_base = b; wr_size = s; wr_type = t;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_cmp(input logic [63:0] b, input logic [63:0] m);
    @(negedge clk);
    cmp_req = 1'b1; cmp_base = b; cmp_mask = m;
    @(negedge clk);
    cmp_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 base", reg_base, 0);
    chk("R1 mask", reg_mask, 0);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    chk("R1 chg", 64'(chg), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      do_write(V_BASE[i], V_SIZE[i], V_TYPE[i]);
      chk("R2 encoded base", reg_base, V_EBASE[i]);
      chk("R3 encoded mask", reg_mask, V_EMASK[i]);
      do_read();
      chk("R5 rd_valid", 64'(rd_valid), 1);
      chk("R5 decoded base", 64'(rd_base), 64'(V_BASE[i]));
      chk("R5 decoded type", 64'(rd_type), 64'(V_TYPE[i]));
      chk("R7 decoded size", 64'(rd_size), 64'(V_SIZE[i]));
      @(negedge clk);
      chk("R5 rd_valid drop", 64'(rd_valid), 0);
    end

    // R4: disable after a valid range
    do_write(24'h000100, 24'h000100, 8'd6);
    do_write(24'h000100, 24'h000000, 8'd6);
    chk("R4 base cleared", reg_base, 0);
    chk("R4 mask cleared", reg_mask, 0);
    do_read();
    chk("R6 size on disabled", 64'(rd_size), 0);

    // R8: only reserved and out-of-width bits differ
    do_write(24'h000100, 24'h000100, 8'd6);
    do_cmp(64'hFFF0_0000_0010_0F06, 64'h1234_000F_FFF0_0FFF);
    chk("R8 chg", 64'(chg), 0);
    chk("R8 base kept", reg_base, 64'h0_0010_0006);
    chk("R8 mask kept", reg_mask, 64'hF_FFF0_0800);

    // R9: type differs, mask same
    do_cmp(64'h0_0010_0000, 64'hF_FFF0_0800);
    chk("R9 chg_base", 64'(chg_base), 1);
    chk("R9 chg_mask", 64'(chg_mask), 0);
    chk("R9 chg", 64'(chg), 1);
    chk("R9 base replaced", reg_base, 64'h0_0010_0000);
    chk("R9 mask kept", reg_mask, 64'hF_FFF0_0800);
    @(negedge clk);
    chk("R9 flag pulse", 64'(chg), 0);

    // R6: valid bit cleared through compare, mask stays non-zero
    do_cmp(64'h0_0010_0000, 64'hF_FFF0_0000);
    chk("R9 chg_mask only", 64'({chg_base, chg_mask}), 64'b01);
    chk("R9 mask replaced", reg_mask, 64'hF_FFF0_0000);
    do_read();
    chk("R6 base zero", 64'(rd_base), 0);
    chk("R6 size zero", 64'(rd_size), 0);
    chk("R6 type zero", 64'(rd_type), 0);

    // R7: valid all-zero mask covers the whole space
    do_cmp(64'h0_0000_0006, 64'h0_0000_0800);
    do_read();
    chk("R7 full span", 64'(rd_size), 64'h100_0000);
    chk("R5 type", 64'(rd_type), 6);

    // R10: write and compare together
    @(negedge clk);
    wr_req = 1'b1; wr_base = 24'h0C0000; wr_size = 24'h040000; wr_type = 8'd0;
    cmp_req = 1'b1; cmp_base = 64'h0_0010_0006; cmp_mask = 64'hF_FFF0_0800;
    @(negedge clk);
    wr_req = 1'b0; cmp_req = 1'b0;
    chk("R10 chg", 64'(chg), 0);
    chk("R10 base from write", reg_base, 64'h0_C000_0000);
    chk("R10 mask from write", reg_mask, 64'hF_C000_0800);

    // R11: read during write sees old pair
    @(negedge clk);
    wr_req = 1'b1; wr_base = 24'h000100; wr_size = 24'h000100; wr_type = 8'd6;
    rd_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    chk("R11 old base", 64'(rd_base), 64'h0C0000);
    chk("R11 old size", 64'(rd_size), 64'h040000);
    chk("R11 new base stored", reg_base, 64'h0_0010_0006);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule